// File: doc/BRIEF.md
# Four-bit registered arithmetic logic unit

This block takes two 4-bit unsigned operands and a 3-bit operation code. On each clock edge where the input strobe is high, it computes one of five operations: add, subtract, increment, bitwise AND or bitwise OR. It stores a 4-bit result and two flags in registers. The carry-out of an add sets the carry flag. The borrow of a subtract sets the borrow flag. Every other operation clears both flags.

The three unused operation codes do nothing. When one of them is strobed, the result and both flags keep the values from the last valid operation. Each result depends only on the operands and code strobed in that cycle. An earlier result has no effect on a later one, even when the same code is issued several times in a row.

Top module: `alu4_reg`

## Requirements
- R1: A synchronous active-high reset clears the result, the carry flag and the borrow flag to 0 on the next rising edge.
- R2: Code 3'b000 stores (a+b) mod 16 in the result. The carry flag is set exactly when a+b exceeds 15.
- R3: Code 3'b001 stores (a-b) mod 16 in the result. The borrow flag is set exactly when b is greater than a.
- R4: Code 3'b010 stores (a+1) mod 16. With a = 4'b1111 the result is 0 and the carry flag stays clear.
- R5: Code 3'b011 stores a & b, and code 3'b100 stores a | b.
- R6: Any operation other than an add clears the carry flag. Any operation other than a subtract clears the borrow flag.
- R7: Codes 3'b101, 3'b110 and 3'b111 leave the result and both flags unchanged.
- R8: When the strobe is low, the result and both flags keep their values whatever the operands and code are.
- R9: The outputs of a strobed operation appear one cycle after the strobe edge. They depend only on that cycle's inputs, not on any earlier result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Input strobe; the operation is registered when high |
| op | input | 3 | Operation code |
| a | input | 4 | First operand |
| b | input | 4 | Second operand |
| res | output | 4 | Registered result |
| carry | output | 1 | Add carry-out flag |
| borrow | output | 1 | Subtract borrow flag |

## Verification
Two functions can meet in one cycle. A flag may be set by one operation and must be cleared by the next. Likewise, a reserved code may arrive while a flag is set, and the flag must then be kept.

The bench provokes the first case with an overflowing add followed at once by a subtract or a logic operation. It provokes the second with a borrowing subtract followed by a reserved code. In random sequences, a model in the bench tracks the expected state and compares every output after each edge, so a stale flag or a lost hold shows up as a mismatch.

// File: rtl/alu4_reg.sv
module alu4_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         borrow
);
  localparam logic [2:0] OP_ADD = 3'b000;
  localparam logic [2:0] OP_SUB = 3'b001;
  localparam logic [2:0] OP_INC = 3'b010;
  localparam logic [2:0] OP_AND = 3'b011;
  localparam logic [2:0] OP_OR  = 3'b100;

  logic [W:0]   sum_x, dif_x, inc_x;
  logic [W-1:0] nxt;
  logic         legal;

  assign sum_x = {1'b0, a} + {1'b0, b};
  assign dif_x = {1'b0, a} - {1'b0, b};
  assign inc_x = {1'b0, a} + 1'b1;
  assign legal = (op <= OP_OR);

  always_comb begin
    case (op)
      OP_ADD:  nxt = sum_x[W-1:0];
      OP_SUB:  nxt = dif_x[W-1:0];
      OP_INC:  nxt = inc_x[W-1:0];
      OP_AND:  nxt = a & b;
      OP_OR:   nxt = a | b;
      default: nxt = res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res    <= '0;
      carry  <= 1'b0;
      borrow <= 1'b0;
    end else if (go && legal) begin
      res    <= nxt;
      carry  <= (op == OP_ADD) && sum_x[W];
      borrow <= (op == OP_SUB) && dif_x[W];
    end
  end
endmodule

module alu4_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic       go,
  input logic [2:0] op,
  input logic [3:0] a,
  input logic [3:0] b,
  input logic [3:0] res,
  input logic       carry,
  input logic       borrow
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_reset_R1: assert property (@(posedge clk) rst |=> (res == 4'd0 && !carry && !borrow));
  assert_add_R2: assert property (@(posedge clk) disable iff (rst)
    (go && op == 3'b000) |=> ({carry, res} == 5'($past(a)) + 5'($past(b))));
  assert_sub_R3: assert property (@(posedge clk) disable iff (rst)
    (go && op == 3'b001) |=> (borrow == ($past(b) > $past(a))));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (go && op == 3'b010) |=> !carry);
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (go && op != 3'b000 && op <= 3'b100) |=> !carry);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    (go && op > 3'b100) |=> ($stable(res) && $stable(carry) && $stable(borrow)));
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    !go |=> ($stable(res) && $stable(carry) && $stable(borrow)));
  assert_excl_R6: assert property (@(posedge clk) !(carry && borrow));
endmodule

bind alu4_reg alu4_reg_chk u_chk (
  .clk(clk), .rst(rst), .go(go), .op(op), .a(a), .b(b),
  .res(res), .carry(carry), .borrow(borrow)
);

// File: tb/tb_alu4_reg.sv
module tb_alu4_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, go = 0;
  logic [2:0] op = 0;
  logic [3:0] a = 0, b = 0;
  logic [3:0] res;
  logic carry, borrow;

  int checks = 0, errors = 0;
  logic [3:0] m_res = 0;
  logic m_c = 0, m_b = 0;

  alu4_reg dut (.clk(clk), .rst(rst), .go(go), .op(op), .a(a), .b(b),
                .res(res), .carry(carry), .borrow(borrow));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] model(input logic [2:0] o, input logic [3:0] x, input logic [3:0] y,
                                       input logic [3:0] r, input logic c, input logic bw);
    logic [4:0] t;
    case (o)
      3'd0: begin t = {1'b0, x} + {1'b0, y}; return {t[3:0], t[4], 1'b0}; end
      3'd1: return {4'(x - y), 1'b0, (y > x)};
      3'd2: return {4'(x + 4'd1), 1'b0, 1'b0};
      3'd3: return {x & y, 1'b0, 1'b0};
      3'd4: return {x | y, 1'b0, 1'b0};
      default: return {r, c, bw};
    endcase
  endfunction

  task automatic check(input string tag);
    checks++;
    if ({res, carry, borrow} !== {m_res, m_c, m_b}) begin
      errors++;
      $display("FAIL %s: got res=%0d c=%0b b=%0b exp res=%0d c=%0b b=%0b",
               tag, res, carry, borrow, m_res, m_c, m_b);
    end
  endtask

  task automatic step(input logic g, input logic [2:0] o, input logic [3:0] x, input logic [3:0] y,
                      input string tag);
    logic [5:0] n;
    go = g; op = o; a = x; b = y;
    if (g) begin
      n = model(o, x, y, m_res, m_c, m_b);
      {m_res, m_c, m_b} = n;
    end
    @(posedge clk); #1;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset");
    rst = 0;
    step(1, 3'd0, 4'hF, 4'hF, "R2 max add carry");
    step(1, 3'd0, 4'd7, 4'd8, "R2 add no carry");
    step(1, 3'd0, 4'd9, 4'd9, "R2 add carry");
    step(1, 3'd1, 4'd3, 4'd5, "R3 R6 borrow after carry");
    step(1, 3'd1, 4'd5, 4'd5, "R3 equal no borrow");
    step(1, 3'd1, 4'd0, 4'hF, "R3 max borrow");
    step(1, 3'd6, 4'd1, 4'd1, "R7 hold 110");
    step(1, 3'd7, 4'd2, 4'd3, "R7 hold 111");
    step(1, 3'd5, 4'd4, 4'd4, "R7 hold 101");
    step(0, 3'd0, 4'hF, 4'hF, "R8 idle");
    step(1, 3'd2, 4'hF, 4'd0, "R4 inc wrap");
    step(1, 3'd0, 4'hF, 4'd1, "R2 carry set");
    step(1, 3'd2, 4'd6, 4'd0, "R4 R6 inc clears carry");
    step(1, 3'd3, 4'b1010, 4'b0110, "R5 and");
    step(1, 3'd4, 4'b1010, 4'b0110, "R5 or");
    step(1, 3'd0, 4'hF, 4'hF, "R9 repeat add");
    step(1, 3'd0, 4'hF, 4'hF, "R9 repeat add");
    rst = 1; @(posedge clk); #1;
    {m_res, m_c, m_b} = '0;
    check("R1 reset mid-run");
    rst = 0;
    for (int i = 0; i < 400; i++)
      step(($urandom % 5) != 0, 3'($urandom), 4'($urandom), 4'($urandom), "R9 random");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule